// File: doc/BRIEF.md
# Auto-Baud Serial Receiver with Sleep Wake

This block turns an asynchronous serial line into bytes. Each frame has one start bit, eight data bits sent least significant bit first, and one stop bit. There is no parity bit. The bit time is set by a baud divisor and a selectable oversampling rate. In the 16x rate the block takes three samples around the middle of each bit and keeps the majority value. In the 4x rate it takes one sample at the middle of the bit. The input first passes through a multiplexer that can select an internal transmit line in place of the receive pin. It then passes through an optional polarity inverter and a two-flop synchronizer. Start-bit detection only happens after these stages.

Software can arm an automatic baud measurement. The next character on the line must be 0x55. The block counts system clocks from the falling edge of that character's start bit to the falling edge that begins its last data bit. That span is eight bit times. The block derives the divisor from the count, loads it, and clears the arm bit by itself. The 0x55 character is not delivered as data.

A separate wake mode watches the line while the system sleeps. A falling edge raises a one-cycle wake interrupt. The wake arm bit then clears on the next rising edge.

Top module: `uart_rx_abaud`

## Requirements
- R1: Frames are one low start bit, eight data bits least significant bit first, and one stop bit. Each completed frame produces a one-cycle `data_valid` pulse, with the byte on `data_out` and its stop status on `frame_err`.
- R2: With `high_speed`=0 a bit lasts (D+1)×16 clocks, where D is `div_out`. Each bit is the majority of three samples around mid-bit, so a one-clock glitch on a single sample does not change the bit.
- R3: With `high_speed`=1 a bit lasts (D+1)×4 clocks and is decided by one sample at mid-bit.
- R4: A low pulse on the line shorter than half a bit fails the mid-bit start check. The receiver returns to idle and no byte is delivered.
- R5: A stop bit sampled low still delivers the byte, with `frame_err`=1 during the `data_valid` pulse. A good stop bit gives `frame_err`=0.
- R6: `overrun` goes to 1 in the cycle after a byte completes while the previous byte has not been acknowledged. `data_ack` given in the same cycle as a completion counts for the older byte, so no overrun is raised. A `data_ack` with no completion clears both the pending state and `overrun`.
- R7: With `invert`=1 the pin idles at 0. The pin is inverted before any edge detection, so an inverted frame gives the same byte.
- R8: With `loopback`=1 the receiver listens to `lb_tx`, and activity on `rx_pin` is ignored.
- R9: A pulse on `abaud_set` sets `abaud_busy`. The next character (0x55) is timed over eight bit times as C clocks. `div_out` becomes round(C/(8×OS))−1, where OS is 16 or 4. `abaud_busy` then clears itself, and no `data_valid` is produced for that character.
- R10: A pulse on `wake_set` sets `wake_armed`. While `en`=1 and `sleep`=1, a falling line edge gives a one-cycle `wake_irq`. `wake_armed` clears on the next rising edge. No bytes are received during sleep.
- R11: While `en`=0 there is no `data_valid` and no `wake_irq`.
- R12: After reset, `data_valid`, `overrun`, `wake_irq`, `wake_armed`, `abaud_busy` and `div_out` are all 0.
- R13: A pulse on `div_wr` loads `divisor_in` into `div_out` at the next edge. If a measurement completes in the same cycle, the measured value wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Receiver enable |
| sleep | input | 1 | System sleep indication |
| rx_pin | input | 1 | Serial receive pin |
| lb_tx | input | 1 | Internal transmit line for loopback |
| loopback | input | 1 | Select `lb_tx` as the receive source |
| invert | input | 1 | Line polarity inversion |
| high_speed | input | 1 | 1 = 4x oversampling, 0 = 16x |
| div_wr | input | 1 | Load `divisor_in` |
| divisor_in | input | DIVW | Baud divisor value |
| abaud_set | input | 1 | Arm the baud measurement |
| wake_set | input | 1 | Arm wake-on-falling-edge |
| data_ack | input | 1 | Acknowledge the delivered byte |
| data_out | output | 8 | Received byte |
| data_valid | output | 1 | One-cycle byte strobe |
| frame_err | output | 1 | Stop bit was low for this byte |
| overrun | output | 1 | Byte lost because it was not acknowledged |
| wake_irq | output | 1 | Wake interrupt pulse |
| wake_armed | output | 1 | Wake mode armed |
| abaud_busy | output | 1 | Baud measurement armed or running |
| div_out | output | DIVW | Active baud divisor |

## Verification
The two events that can land in the same clock edge are a byte completing and its acknowledge. The monitor raises `data_ack` in the very cycle it sees `data_valid`, so the design samples both at one edge. The bench first leaves one byte unacknowledged. The next byte is then acknowledged in its own completion cycle, and `overrun` must stay 0. A third byte sent with no acknowledge must then set `overrun`. A lone acknowledge must clear it again.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned FRAME_BITS = 8;
  localparam int unsigned OS_STD     = 16;
  localparam int unsigned OS_FAST    = 4;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_front.sv
module uart_rx_front (
  input  logic clk,
  input  logic rst,
  input  logic rx_pin,
  input  logic lb_tx,
  input  logic loopback,
  input  logic invert,
  output logic line,
  output logic fall,
  output logic rise
);
  logic raw;
  logic s1, s2, s3;

  // source select and polarity correction ahead of the synchronizer
  assign raw = (loopback ? lb_tx : rx_pin) ^ invert;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= raw;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign line = s2;
  assign fall = s3 & ~s2;
  assign rise = ~s3 & s2;
endmodule

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int unsigned DIVW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  assign tick = (cnt >= div) && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart)  cnt <= '0;
    else if (cnt >= div) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
  import uart_rx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hold,
  input  logic                  line,
  input  logic                  fall,
  input  logic                  tick,
  input  logic                  fast,
  output logic                  restart,
  output logic                  done,
  output logic [FRAME_BITS-1:0] data,
  output logic                  ferr
);
  localparam int unsigned SCW = $clog2(OS_STD);
  localparam int unsigned BNW = $clog2(FRAME_BITS);

  rx_state_e             st;
  logic [SCW-1:0]        sc;
  logic [BNW-1:0]        bn;
  logic [FRAME_BITS-1:0] sh;
  logic                  v0, v1, v2;
  logic [SCW-1:0]        last, mid, fin;
  logic                  bitv;

  assign last = fast ? SCW'(OS_FAST - 1) : SCW'(OS_STD - 1);
  assign mid  = fast ? SCW'(OS_FAST / 2) : SCW'(OS_STD / 2);
  assign fin  = fast ? SCW'(OS_FAST / 2 + 1) : SCW'(OS_STD / 2 + 2);
  assign bitv = fast ? v1 : ((v0 & v1) | (v0 & v2) | (v1 & v2));

  assign restart = (st == RX_IDLE) && fall && !hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RX_IDLE;
      sc   <= '0;
      bn   <= '0;
      sh   <= '0;
      v0   <= 1'b1;
      v1   <= 1'b1;
      v2   <= 1'b1;
      done <= 1'b0;
      data <= '0;
      ferr <= 1'b0;
    end else if (hold) begin
      st   <= RX_IDLE;
      sc   <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == RX_IDLE) begin
        if (fall) begin
          st <= RX_START;
          sc <= '0;
        end
      end else if (tick) begin
        if (sc == mid - 1'b1) v0 <= line;
        if (sc == mid)        v1 <= line;
        if (sc == mid + 1'b1) v2 <= line;
        sc <= (sc == last) ? '0 : sc + 1'b1;
        case (st)
          RX_START: begin
            if (sc == mid && line) begin
              st <= RX_IDLE;           // start not confirmed
            end else if (sc == last) begin
              st <= RX_DATA;
              bn <= '0;
            end
          end
          RX_DATA: begin
            if (sc == last) begin
              sh <= {bitv, sh[FRAME_BITS-1:1]};
              bn <= bn + 1'b1;
              if (bn == BNW'(FRAME_BITS - 1)) st <= RX_STOP;
            end
          end
          default: begin
            if (sc == fin) begin
              data <= sh;
              ferr <= !bitv;
              done <= 1'b1;
              st   <= RX_IDLE;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_measure.sv
module uart_rx_measure
  import uart_rx_pkg::*;
#(
  parameter int unsigned DIVW = 12,
  parameter int unsigned CNTW = DIVW + 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            fall,
  input  logic            fast,
  output logic            done,
  output logic [DIVW-1:0] meas
);
  localparam int unsigned EDGES    = FRAME_BITS / 2;
  localparam int unsigned SH_STD   = $clog2(FRAME_BITS * OS_STD);
  localparam int unsigned SH_FAST  = $clog2(FRAME_BITS * OS_FAST);
  localparam int unsigned HALF_STD = FRAME_BITS * OS_STD / 2;
  localparam int unsigned HALF_FST = FRAME_BITS * OS_FAST / 2;

  logic            run;
  logic [2:0]      edges;
  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] rnd;
  logic [DIVW-1:0] meas_nx;

  always_comb begin
    if (fast) rnd = (cnt + CNTW'(HALF_FST)) >> SH_FAST;
    else      rnd = (cnt + CNTW'(HALF_STD)) >> SH_STD;
    meas_nx = (rnd == '0) ? '0 : DIVW'(rnd - CNTW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      edges <= '0;
      cnt   <= '0;
      done  <= 1'b0;
      meas  <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        run <= 1'b0;
      end else if (!run) begin
        if (fall) begin
          run   <= 1'b1;
          cnt   <= CNTW'(1);
          edges <= '0;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (fall) begin
          if (edges == 3'(EDGES - 1)) begin
            run  <= 1'b0;
            done <= 1'b1;
            meas <= meas_nx;
          end else begin
            edges <= edges + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_abaud.sv
module uart_rx_abaud
  import uart_rx_pkg::*;
#(
  parameter int unsigned DIVW = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  sleep,
  input  logic                  rx_pin,
  input  logic                  lb_tx,
  input  logic                  loopback,
  input  logic                  invert,
  input  logic                  high_speed,
  input  logic                  div_wr,
  input  logic [DIVW-1:0]       divisor_in,
  input  logic                  abaud_set,
  input  logic                  wake_set,
  input  logic                  data_ack,
  output logic [FRAME_BITS-1:0] data_out,
  output logic                  data_valid,
  output logic                  frame_err,
  output logic                  overrun,
  output logic                  wake_irq,
  output logic                  wake_armed,
  output logic                  abaud_busy,
  output logic [DIVW-1:0]       div_out
);
  logic            line, line_fall, line_rise;
  logic            restart, tick, hold;
  logic            ab_done;
  logic [DIVW-1:0] meas;
  logic            pend, wake_seen;

  assign hold = !en || sleep || abaud_busy;

  uart_rx_front u_front (
    .clk(clk), .rst(rst), .rx_pin(rx_pin), .lb_tx(lb_tx),
    .loopback(loopback), .invert(invert),
    .line(line), .fall(line_fall), .rise(line_rise)
  );

  uart_rx_baud #(.DIVW(DIVW)) u_baud (
    .clk(clk), .rst(rst), .restart(restart), .div(div_out), .tick(tick)
  );

  uart_rx_deframer u_deframer (
    .clk(clk), .rst(rst), .hold(hold), .line(line), .fall(line_fall),
    .tick(tick), .fast(high_speed), .restart(restart),
    .done(data_valid), .data(data_out), .ferr(frame_err)
  );

  uart_rx_measure #(.DIVW(DIVW)) u_measure (
    .clk(clk), .rst(rst), .active(en && abaud_busy), .fall(line_fall),
    .fast(high_speed), .done(ab_done), .meas(meas)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      abaud_busy <= 1'b0;
      div_out    <= '0;
      pend       <= 1'b0;
      overrun    <= 1'b0;
      wake_armed <= 1'b0;
      wake_seen  <= 1'b0;
      wake_irq   <= 1'b0;
    end else begin
      if (abaud_set)    abaud_busy <= 1'b1;
      else if (ab_done) abaud_busy <= 1'b0;

      if (ab_done)     div_out <= meas;
      else if (div_wr) div_out <= divisor_in;

      if (data_valid) begin
        pend <= 1'b1;
        if (pend && !data_ack) overrun <= 1'b1;
      end else if (data_ack) begin
        pend    <= 1'b0;
        overrun <= 1'b0;
      end

      wake_irq <= 1'b0;
      if (en && sleep && wake_armed) begin
        if (line_fall) begin
          wake_irq  <= 1'b1;
          wake_seen <= 1'b1;
        end else if (line_rise && wake_seen) begin
          wake_armed <= 1'b0;
          wake_seen  <= 1'b0;
        end
      end
      if (wake_set) wake_armed <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_abaud_chk.sv
module uart_rx_abaud_chk #(
  parameter int unsigned DIVW = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic            sleep,
  input logic            div_wr,
  input logic [DIVW-1:0] divisor_in,
  input logic            data_valid,
  input logic            overrun,
  input logic            wake_irq,
  input logic            wake_armed,
  input logic            abaud_busy,
  input logic [DIVW-1:0] div_out,
  input logic            line_rise,
  input logic            ab_done
);
  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    data_valid |=> !data_valid);

  p_overrun_src_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(data_valid));

  p_sync_hidden_r9: assert property (@(posedge clk) disable iff (rst)
    (abaud_busy && $past(abaud_busy)) |-> !data_valid);

  p_wake_src_r10: assert property (@(posedge clk) disable iff (rst)
    wake_irq |-> ($past(sleep) && $past(en) && $past(wake_armed)));

  p_wake_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(wake_armed) |-> $past(line_rise));

  p_quiet_off_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!data_valid && !wake_irq));

  p_div_load_r13: assert property (@(posedge clk) disable iff (rst)
    ($past(div_wr) && !$past(ab_done)) |-> (div_out == $past(divisor_in)));
endmodule

bind uart_rx_abaud uart_rx_abaud_chk #(.DIVW(DIVW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .sleep(sleep), .div_wr(div_wr),
  .divisor_in(divisor_in), .data_valid(data_valid), .overrun(overrun),
  .wake_irq(wake_irq), .wake_armed(wake_armed), .abaud_busy(abaud_busy),
  .div_out(div_out), .line_rise(line_rise), .ab_done(ab_done)
);

// File: tb/uart_rx_abaud_test.sv
module uart_rx_abaud_test;
  localparam int DIVW = 12;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, sleep = 1'b0;
  logic rx_pin = 1'b1, lb_tx = 1'b1, loopback = 1'b0, invert = 1'b0;
  logic high_speed = 1'b0, div_wr = 1'b0, abaud_set = 1'b0, wake_set = 1'b0;
  logic data_ack = 1'b0;
  logic [DIVW-1:0] divisor_in = '0;
  logic [7:0] data_out;
  logic data_valid, frame_err, overrun, wake_irq, wake_armed, abaud_busy;
  logic [DIVW-1:0] div_out;

  int checks = 0, fails = 0, rx_count = 0, wake_count = 0;
  int ack_req = 0, ack_seen = 0;
  bit auto_ack = 1'b1, use_lb = 1'b0, use_inv = 1'b0, ended = 1'b0;
  logic [8:0] exp_q[$];

  uart_rx_abaud #(.DIVW(DIVW)) uut (
    .clk(clk), .rst(rst), .en(en), .sleep(sleep), .rx_pin(rx_pin),
    .lb_tx(lb_tx), .loopback(loopback), .invert(invert),
    .high_speed(high_speed), .div_wr(div_wr), .divisor_in(divisor_in),
    .abaud_set(abaud_set), .wake_set(wake_set), .data_ack(data_ack),
    .data_out(data_out), .data_valid(data_valid), .frame_err(frame_err),
    .overrun(overrun), .wake_irq(wake_irq), .wake_armed(wake_armed),
    .abaud_busy(abaud_busy), .div_out(div_out)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic put_level(logic v);
    if (use_lb) lb_tx = v;
    else        rx_pin = v ^ use_inv;
  endtask

  task automatic drive_bit(logic v, int n, bit glitch);
    put_level(v);
    if (glitch) begin
      repeat (36) @(posedge clk);
      #2 put_level(~v);
      @(posedge clk);
      #2 put_level(v);
      repeat (n - 37) @(posedge clk);
    end else begin
      repeat (n) @(posedge clk);
    end
    #2;
  endtask

  task automatic send_frame(logic [7:0] b, int n, logic stopv, int gbit);
    @(posedge clk);
    #2;
    drive_bit(1'b0, n, 1'b0);
    for (int i = 0; i < 8; i++) drive_bit(b[i], n, gbit == i);
    drive_bit(stopv, n, 1'b0);
    drive_bit(1'b1, n, 1'b0);
  endtask

  task automatic send_exp(logic [7:0] b, int n, logic stopv, int gbit);
    exp_q.push_back({~stopv, b});
    send_frame(b, n, stopv, gbit);
  endtask

  task automatic pulse_div(logic [DIVW-1:0] d);
    @(posedge clk);
    #2 divisor_in = d; div_wr = 1'b1;
    @(posedge clk);
    #2 div_wr = 1'b0;
  endtask

  // scoreboard monitor; raises data_ack in the same cycle as data_valid
  initial begin
    forever begin
      @(posedge clk);
      #1;
      data_ack = 1'b0;
      if (!rst && data_valid) begin
        rx_count++;
        if (exp_q.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL R1 unexpected byte: actual %0h expected none", data_out);
        end else begin
          check("R1/R5 scoreboard {ferr,data}", {23'd0, frame_err, data_out}, {23'd0, exp_q.pop_front()});
        end
        data_ack = auto_ack;
      end else if (ack_req != ack_seen) begin
        data_ack = 1'b1;
        ack_seen = ack_req;
      end
      if (!rst && wake_irq) wake_count++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int c0, w0;
    repeat (5) @(posedge clk);
    #2 rst = 1'b0; en = 1'b1;
    check("R12 data_valid", data_valid, 0);
    check("R12 overrun", overrun, 0);
    check("R12 wake_irq", wake_irq, 0);
    check("R12 wake_armed", wake_armed, 0);
    check("R12 abaud_busy", abaud_busy, 0);
    check("R12 div_out", div_out, 0);

    pulse_div(12'd3);
    check("R13 div_out after write", div_out, 3);

    // 16x, bit = 64 clocks
    send_exp(8'hA5, 64, 1'b1, -1);
    send_exp(8'h3C, 64, 1'b1, 5);   // single-sample glitch on bit 5
    check("R2 bytes received", rx_count, 2);

    // short low pulse
    c0 = rx_count;
    put_level(1'b0);
    repeat (20) @(posedge clk);
    #2 put_level(1'b1);
    repeat (200) @(posedge clk);
    #2;
    check("R4 false start ignored", rx_count, c0);
    send_exp(8'h01, 64, 1'b1, -1);

    send_exp(8'h7E, 64, 1'b0, -1);  // low stop bit

    // overrun sequence
    ack_req++;
    repeat (4) @(posedge clk);
    #2;
    check("R6 cleared by lone ack", overrun, 0);
    auto_ack = 1'b0;
    send_exp(8'h11, 64, 1'b1, -1);
    check("R6 first unacked byte", overrun, 0);
    auto_ack = 1'b1;
    send_exp(8'h22, 64, 1'b1, -1);
    check("R6 coincident ack no overrun", overrun, 0);
    auto_ack = 1'b0;
    send_exp(8'h33, 64, 1'b1, -1);
    check("R6 overrun set", overrun, 1);
    ack_req++;
    repeat (4) @(posedge clk);
    #2;
    check("R6 overrun cleared", overrun, 0);
    auto_ack = 1'b1;

    // 4x, bit = 16 clocks
    high_speed = 1'b1;
    send_exp(8'h96, 16, 1'b1, -1);
    send_exp(8'h0F, 16, 1'b1, -1);
    check("R3 fast bytes", rx_count, 9);
    high_speed = 1'b0;

    // inverted polarity
    @(posedge clk);
    #2 use_inv = 1'b1; invert = 1'b1; put_level(1'b1);
    send_exp(8'h5A, 64, 1'b1, -1);
    check("R7 inverted byte", rx_count, 10);
    #2 use_inv = 1'b0; invert = 1'b0; put_level(1'b1);

    // loopback with a low rx pin
    @(posedge clk);
    #2 loopback = 1'b1; use_lb = 1'b1; lb_tx = 1'b1;
    @(posedge clk);
    #2 rx_pin = 1'b0;
    send_exp(8'hC3, 64, 1'b1, -1);
    check("R8 loopback byte", rx_count, 11);
    rx_pin = 1'b1;
    repeat (8) @(posedge clk);
    #2 loopback = 1'b0; use_lb = 1'b0;

    // auto-baud 16x, true bit = 96 clocks -> divisor 5
    pulse_div(12'd0);
    @(posedge clk);
    #2 abaud_set = 1'b1;
    @(posedge clk);
    #2 abaud_set = 1'b0;
    check("R9 busy armed", abaud_busy, 1);
    c0 = rx_count;
    send_frame(8'h55, 96, 1'b1, -1);
    check("R9 busy self-cleared", abaud_busy, 0);
    check("R9 measured divisor 16x", div_out, 5);
    check("R9 sync not delivered", rx_count, c0);
    send_exp(8'h81, 96, 1'b1, -1);
    check("R9 byte at measured rate", rx_count, c0 + 1);

    // auto-baud 4x, bit = 32 clocks -> divisor 7
    high_speed = 1'b1;
    @(posedge clk);
    #2 abaud_set = 1'b1;
    @(posedge clk);
    #2 abaud_set = 1'b0;
    send_frame(8'h55, 32, 1'b1, -1);
    check("R9 measured divisor 4x", div_out, 7);
    send_exp(8'hE7, 32, 1'b1, -1);
    high_speed = 1'b0;
    pulse_div(12'd3);

    // wake during sleep
    @(posedge clk);
    #2 sleep = 1'b1; wake_set = 1'b1;
    @(posedge clk);
    #2 wake_set = 1'b0;
    check("R10 wake armed", wake_armed, 1);
    c0 = rx_count;
    w0 = wake_count;
    put_level(1'b0);
    repeat (200) @(posedge clk);
    #2;
    check("R10 one wake pulse", wake_count, w0 + 1);
    check("R10 armed until rise", wake_armed, 1);
    put_level(1'b1);
    repeat (6) @(posedge clk);
    #2;
    check("R10 armed cleared on rise", wake_armed, 0);
    check("R10 no bytes in sleep", rx_count, c0);
    sleep = 1'b0;

    // disabled
    en = 1'b0;
    c0 = rx_count;
    send_frame(8'h42, 64, 1'b1, -1);
    check("R11 no byte when off", rx_count, c0);
    sleep = 1'b1;
    @(posedge clk);
    #2 wake_set = 1'b1;
    @(posedge clk);
    #2 wake_set = 1'b0;
    w0 = wake_count;
    put_level(1'b0);
    repeat (50) @(posedge clk);
    #2 put_level(1'b1);
    repeat (10) @(posedge clk);
    #2;
    check("R11 no wake when off", wake_count, w0);
    sleep = 1'b0;
    en = 1'b1;
    repeat (10) @(posedge clk);
    #2;
    check("R1 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule